// File: doc/BRIEF.md
# Pin configuration lock sequencer

This block guards the per-pin configuration of a general-purpose I/O port. Software arms the guard by driving a key sequence into a single lock register. The sequence is three full-word writes and then one full-word read, and the pin mask in the low bits must be the same in every write. When the read completes the sequence, the mask is frozen and the lock status bit reads 1. From that point until reset, the configuration fields of every masked pin refuse writes.

The configuration register decoder in front of the block presents two things: a one-hot selector of the configuration register being written, and the set of pins that the write touches. There are six such registers: mode, output type, speed, pull, and two alternate-function banks. The block returns a per-register, per-pin write enable with the locked pins removed. Writes to the output data and bit set/clear registers are passed through unchanged.

Any access to the lock register that breaks the sequence sends the sequencer back to idle, and the sequence must then start again from its first write. The ways to break it are: the wrong key value, a mask that differs from the one held, or an access narrower than a full word.

Top module: `gpio_cfg_lock`

## Requirements
- R1: After reset, `lk_rdata` is zero and every configuration write request is passed through ungated.
- R2: Four accesses complete the lock, in this order: a full-word write with bit 16 = 1, a full-word write with bit 16 = 0 and the same bits 15:0, a full-word write with bit 16 = 1 and the same bits 15:0, then a full-word read. The read that completes the lock still returns bit 16 = 0. Every later read returns bit 16 = 1.
- R3: While the lock is not complete, `cfg_wen[r*16+p]` equals `cfg_sel[r] & cfg_pins[p]` for every register index r (0..5) and pin p.
- R4: Once locked, `cfg_wen[r*16+p]` equals `cfg_sel[r] & cfg_pins[p] & ~mask[p]`, with the same rule applied to all six register indices.
- R5: A write whose bit 16 is wrong for the current step sends the sequencer to idle. That write does not itself count as a first step.
- R6: A write during the sequence whose bits 15:0 differ from the held mask sends the sequencer to idle.
- R7: An access with `lk_word` = 0 never loads the mask. Such an access part-way through the sequence sends the sequencer to idle.
- R8: A full-word read before the third write leaves the sequence where it is.
- R9: Once locked, lock-register writes change neither the mask nor the status until reset, and reset clears both.
- R10: `dat_wen` always equals `dat_pins`, locked or not.
- R11: `lk_rdata` bits 31:17 read 0. Bits 15:0 show the mask of the last full-word write taken while unlocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_wr | input | 1 | Write strobe for the lock register |
| lk_rd | input | 1 | Read strobe for the lock register |
| lk_word | input | 1 | 1 = full 32-bit access, 0 = narrower access |
| lk_wdata | input | 32 | Write data: bit 16 key, bits 15:0 pin mask |
| lk_rdata | output | 32 | Read data: bit 16 lock status, bits 15:0 mask |
| cfg_sel | input | 6 | One-hot selector of the configuration register being written |
| cfg_pins | input | 16 | Pins whose fields the configuration write touches |
| cfg_wen | output | 96 | Gated write enables, index register*16 + pin |
| dat_pins | input | 16 | Pins touched by an output-data or set/clear write |
| dat_wen | output | 16 | Write enables for output-data pins, never gated |

## Verification
The assertions assume that `lk_wr` and `lk_rd` are never high in the same cycle, and that `cfg_sel` has at most one bit set. Both follow from a register decoder that serves one address per cycle. The bench's access task raises only one lock strobe per cycle and draws the selector as either zero or a single shifted bit. The random mask is drawn from just two values, so that the random key and mask choices complete real lock sequences now and then, in between the aborts.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_STEP1,
    LK_STEP2,
    LK_STEP3,
    LK_HELD
  } lk_state_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
  import gpio_lock_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             word,
  input  logic             wkey,
  input  logic [NPINS-1:0] wmask,
  output logic             locked,
  output logic [NPINS-1:0] mask
);
  lk_state_e        state_q, state_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic             mask_en;
  logic             same_mask;

  assign same_mask = (wmask == mask_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_IDLE: begin
        if (wr && word && wkey) state_d = LK_STEP1;
      end
      LK_STEP1: begin
        if ((wr || rd) && !word) state_d = LK_IDLE;
        else if (wr)             state_d = (!wkey && same_mask) ? LK_STEP2 : LK_IDLE;
      end
      LK_STEP2: begin
        if ((wr || rd) && !word) state_d = LK_IDLE;
        else if (wr)             state_d = (wkey && same_mask) ? LK_STEP3 : LK_IDLE;
      end
      LK_STEP3: begin
        if (wr)                  state_d = LK_IDLE;
        else if (rd)             state_d = word ? LK_HELD : LK_IDLE;
      end
      LK_HELD:  state_d = LK_HELD;
      default:  state_d = LK_IDLE;
    endcase
  end

  always_comb begin
    mask_en = (state_q != LK_HELD) && wr && word;
    mask_d  = wmask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LK_IDLE;
      mask_q  <= '0;
    end else begin
      state_q <= state_d;
      if (mask_en) mask_q <= mask_d;
    end
  end

  assign locked = (state_q == LK_HELD);
  assign mask   = mask_q;
endmodule

// File: rtl/gpio_cfg_gate.sv
module gpio_cfg_gate #(
  parameter int NPINS = 16,
  parameter int NCFG  = 6
) (
  input  logic [NCFG-1:0]       sel,
  input  logic [NPINS-1:0]      pins,
  input  logic [NPINS-1:0]      frozen,
  output logic [NCFG*NPINS-1:0] wen
);
  for (genvar r = 0; r < NCFG; r++) begin : g_reg
    assign wen[r*NPINS +: NPINS] = {NPINS{sel[r]}} & pins & ~frozen;
  end
endmodule

// File: rtl/gpio_cfg_lock.sv
module gpio_cfg_lock #(
  parameter int NPINS  = 16,
  parameter int NCFG   = 6,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_wr,
  input  logic                   lk_rd,
  input  logic                   lk_word,
  input  logic [DATA_W-1:0]      lk_wdata,
  output logic [DATA_W-1:0]      lk_rdata,
  input  logic [NCFG-1:0]        cfg_sel,
  input  logic [NPINS-1:0]       cfg_pins,
  output logic [NCFG*NPINS-1:0]  cfg_wen,
  input  logic [NPINS-1:0]       dat_pins,
  output logic [NPINS-1:0]       dat_wen
);
  localparam int KEY_BIT = NPINS;
  localparam int PAD_W   = DATA_W - KEY_BIT - 1;

  logic             rst_n_sync;
  logic             locked;
  logic [NPINS-1:0] mask;
  logic [NPINS-1:0] frozen;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  gpio_lock_seq #(.NPINS(NPINS)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr     (lk_wr),
    .rd     (lk_rd),
    .word   (lk_word),
    .wkey   (lk_wdata[KEY_BIT]),
    .wmask  (lk_wdata[NPINS-1:0]),
    .locked (locked),
    .mask   (mask)
  );

  assign frozen = locked ? mask : '0;

  gpio_cfg_gate #(.NPINS(NPINS), .NCFG(NCFG)) u_gate (
    .sel    (cfg_sel),
    .pins   (cfg_pins),
    .frozen (frozen),
    .wen    (cfg_wen)
  );

  assign lk_rdata = {{PAD_W{1'b0}}, locked, mask};
  assign dat_wen  = dat_pins;
endmodule

// File: rtl/gpio_cfg_lock_chk.sv
module gpio_cfg_lock_chk #(
  parameter int NPINS  = 16,
  parameter int NCFG   = 6,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  lk_rd,
  input logic                  lk_word,
  input logic [DATA_W-1:0]     lk_rdata,
  input logic [NCFG-1:0]       cfg_sel,
  input logic [NPINS-1:0]      cfg_pins,
  input logic [NCFG*NPINS-1:0] cfg_wen
);
  localparam int KEY_BIT = NPINS;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rdata[KEY_BIT] |=> lk_rdata[KEY_BIT]); // R9
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rdata[KEY_BIT] |=> $stable(lk_rdata[NPINS-1:0])); // R9
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rdata[DATA_W-1:KEY_BIT+1] == '0); // R11
  AST_LOCK_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lk_rdata[KEY_BIT]) |-> $past(lk_rd && lk_word)); // R2

  for (genvar r = 0; r < NCFG; r++) begin : g_chk
    AST_NO_STRAY_WEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wen[r*NPINS +: NPINS] & ~({NPINS{cfg_sel[r]}} & cfg_pins)) == '0); // R4
    AST_LOCKED_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      lk_rdata[KEY_BIT] |-> (cfg_wen[r*NPINS +: NPINS] & lk_rdata[NPINS-1:0]) == '0); // R4
    AST_OPEN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_rdata[KEY_BIT] |-> cfg_wen[r*NPINS +: NPINS] == ({NPINS{cfg_sel[r]}} & cfg_pins)); // R3
  end
endmodule

bind gpio_cfg_lock gpio_cfg_lock_chk #(.NPINS(NPINS), .NCFG(NCFG), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_rd    (lk_rd),
  .lk_word  (lk_word),
  .lk_rdata (lk_rdata),
  .cfg_sel  (cfg_sel),
  .cfg_pins (cfg_pins),
  .cfg_wen  (cfg_wen)
);

// File: tb/gpio_cfg_lock_test.sv
module gpio_cfg_lock_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 16;
  localparam int NC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          lk_wr, lk_rd, lk_word;
  logic [31:0]   lk_wdata, lk_rdata;
  logic [NC-1:0] cfg_sel;
  logic [NP-1:0] cfg_pins, dat_pins, dat_wen;
  logic [NC*NP-1:0] cfg_wen;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  int          m_step;   // 0 idle, 1..3 steps done, 4 held
  logic [15:0] m_mask;

  gpio_cfg_lock uut (
    .clk(clk), .rst_n(rst_n), .lk_wr(lk_wr), .lk_rd(lk_rd), .lk_word(lk_word),
    .lk_wdata(lk_wdata), .lk_rdata(lk_rdata), .cfg_sel(cfg_sel), .cfg_pins(cfg_pins),
    .cfg_wen(cfg_wen), .dat_pins(dat_pins), .dat_wen(dat_wen)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD*150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  task automatic chk(input logic [127:0] act, input logic [127:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NC*NP-1:0] exp_wen(input logic [NC-1:0] sel,
      input logic [NP-1:0] pins, input logic held, input logic [NP-1:0] msk);
    logic [NC*NP-1:0] v;
    for (int r = 0; r < NC; r++)
      v[r*NP +: NP] = sel[r] ? (pins & ~(held ? msk : 16'h0)) : 16'h0;
    return v;
  endfunction

  function automatic logic [31:0] exp_rd();
    return {15'h0, (m_step == 4), m_mask};
  endfunction

  task automatic model(input logic wr, input logic rd, input logic word,
                       input logic key, input logic [15:0] msk);
    logic same;
    same = (msk == m_mask);
    case (m_step)
      0: if (wr && word && key) m_step = 1;
      1: if ((wr || rd) && !word) m_step = 0;
         else if (wr) m_step = (!key && same) ? 2 : 0;
      2: if ((wr || rd) && !word) m_step = 0;
         else if (wr) m_step = (key && same) ? 3 : 0;
      3: if (wr) m_step = 0;
         else if (rd) m_step = word ? 4 : 0;
      default: ;
    endcase
    if (m_step_before_held && wr && word) m_mask = msk;
  endtask

  logic m_step_before_held;

  // one lock-register access; checks read data and gating before the edge
  task automatic acc(input logic wr, input logic rd, input logic word,
                     input logic key, input logic [15:0] msk, input string req);
    logic [NC-1:0] s;
    logic [NP-1:0] p;
    @(negedge clk);
    s = ($urandom_range(0, 6) == 6) ? '0 : NC'(1) << $urandom_range(0, NC-1);
    p = NP'($urandom);
    lk_wr = wr; lk_rd = rd; lk_word = word;
    lk_wdata = {$urandom} & 32'hFFFE_0000 | {15'h0, key, msk};
    cfg_sel = s; cfg_pins = p; dat_pins = NP'($urandom);
    #1;
    chk(lk_rdata, exp_rd(), {req, "/R11 read"});
    chk(cfg_wen, exp_wen(s, p, m_step == 4, m_mask), (m_step == 4) ? "R4 gated" : "R3 open");
    chk(dat_wen, dat_pins, "R10 data pass");
    @(posedge clk);
    m_step_before_held = (m_step != 4);
    model(wr, rd, word, key, msk);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    lk_wr = 0; lk_rd = 0; lk_word = 0; lk_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    lk_wr = 0; lk_rd = 0; lk_word = 0; lk_wdata = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    m_step = 0; m_mask = '0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; lk_wr = 0; lk_rd = 0; lk_word = 0; lk_wdata = '0;
    cfg_sel = '0; cfg_pins = '0; dat_pins = '0;
    m_step_before_held = 1;
    do_reset();

    // R1 reset state
    cfg_sel = 6'b000100; cfg_pins = 16'hFFFF; #1;
    chk(lk_rdata, 32'h0, "R1 rdata");
    chk(cfg_wen, exp_wen(6'b000100, 16'hFFFF, 1'b0, 16'h0), "R1 ungated");

    // R2 with an R8 read in the middle
    acc(1, 0, 1, 1, 16'hA5C3, "R2 step1");
    acc(0, 1, 1, 0, 16'h0000, "R8 mid read");
    acc(1, 0, 1, 0, 16'hA5C3, "R2 step2");
    acc(1, 0, 1, 1, 16'hA5C3, "R3 step3");
    acc(0, 1, 1, 0, 16'h0000, "R2 final read");
    idle_cycle(); #1;
    chk(lk_rdata, 32'h0001_A5C3, "R2 locked read");
    chk(m_step, 4, "R8 model agrees");

    // R4 per register
    for (int r = 0; r < NC; r++) begin
      cfg_sel = NC'(1) << r; cfg_pins = 16'hFFFF; #1;
      chk(cfg_wen, exp_wen(NC'(1) << r, 16'hFFFF, 1'b1, 16'hA5C3), "R4 per register");
    end
    dat_pins = 16'hFFFF; #1;
    chk(dat_wen, 16'hFFFF, "R10 locked data pass");

    // R9 writes after lock ignored
    acc(1, 0, 1, 1, 16'h00FF, "R9 write");
    acc(1, 0, 1, 0, 16'h1111, "R9 write");
    idle_cycle(); #1;
    chk(lk_rdata, 32'h0001_A5C3, "R9 unchanged");
    do_reset(); #1;
    chk(lk_rdata, 32'h0, "R9 reset clears");

    // R5 wrong key
    acc(1, 0, 1, 1, 16'h0F0F, "R5");
    acc(1, 0, 1, 1, 16'h0F0F, "R5 wrong key");
    acc(1, 0, 1, 0, 16'h0F0F, "R5");
    acc(1, 0, 1, 1, 16'h0F0F, "R5");
    acc(0, 1, 1, 0, 16'h0, "R5");
    idle_cycle(); #1;
    chk(lk_rdata[16], 1'b0, "R5 not locked");

    // R6 changed mask
    do_reset();
    acc(1, 0, 1, 1, 16'h00F0, "R6");
    acc(1, 0, 1, 0, 16'h00F1, "R6 changed mask");
    acc(1, 0, 1, 1, 16'h00F1, "R6");
    acc(0, 1, 1, 0, 16'h0, "R6");
    idle_cycle(); #1;
    chk(lk_rdata[16], 1'b0, "R6 not locked");

    // R7 partial access
    do_reset();
    acc(1, 0, 1, 1, 16'h3C3C, "R7");
    acc(1, 0, 0, 0, 16'hFFFF, "R7 partial");
    idle_cycle(); #1;
    chk(lk_rdata, 32'h0000_3C3C, "R7 mask not loaded");
    acc(1, 0, 1, 1, 16'h3C3C, "R7");
    acc(0, 1, 1, 0, 16'h0, "R7");
    idle_cycle(); #1;
    chk(lk_rdata[16], 1'b0, "R7 not locked");

    // R11 plain mask load
    acc(1, 0, 1, 0, 16'h1234, "R11");
    idle_cycle(); #1;
    chk(lk_rdata, 32'h0000_1234, "R11 mask shown");

    // random mix
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [15:0] mk;
      if (i % 60 == 59) do_reset();
      op = $urandom_range(0, 9);
      mk = $urandom_range(0, 1) ? 16'hC00B : 16'h0420;
      if (op < 6)      acc(1, 0, $urandom_range(0, 7) != 0, 1'($urandom), mk, "R2 random write");
      else if (op < 9) acc(0, 1, $urandom_range(0, 7) != 0, 1'b0, mk, "R2 random read");
      else             acc(0, 0, 1, 1'b0, mk, "R3 random idle");
    end

    idle_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule